// File: doc/BRIEF.md
# Sequential Multiply-Accumulate FIR Filter Engine

This block is a time-multiplexed FIR filter built around one shared, pipelined multiply-accumulate datapath. When a new input sample is accepted it enters a delay line. A tap sequencer then walks the coefficient store and the delay line in lockstep, one coefficient and its matching past sample per clock. Each product is scaled and registered, then added into a wrapping accumulator.

Once the last tap has been added, the finished sum is registered onto the output port with a one-cycle valid pulse. In that same cycle the accumulator returns to zero. An N-tap output is ready N+1 clocks after its sample is accepted. The extra clock comes from the register between the multiplier and the accumulator.

Coefficients are loaded through a plain write port, one tap per write, while the engine is idle. The upstream source offers samples with a valid signal and watches a ready signal. The engine takes a new sample only when the sequencer is idle.

Top module: `fir_mac_engine`

## Requirements
- R1: After synchronous active-high reset, out_valid is 0, out_data is 0, in_ready is 1, and every delay-line entry is zero. The first output therefore depends only on the first sample accepted.
- R2: A sample is accepted only on a clock edge where in_valid and in_ready are both 1. An in_valid offered while in_ready is 0 leaves the delay line and all later outputs unchanged.
- R3: Each accepted sample shifts the delay line by one place. The result for sample n is the sum over k = 0..NTAPS-1 of scaled(coef[k] * x[n-k]), where coef[k] is the coefficient written at address k.
- R4: Samples and coefficients are signed two's complement. Each full product is shifted arithmetically right by DROP = 4 bits, which rounds toward minus infinity. The shifted product is then sign-extended or truncated to ACC_W = 16 bits before it is added.
- R5: out_valid rises exactly NTAPS+1 clock edges after the accepting edge and stays high for one cycle only. out_data holds the result in that cycle.
- R6: The accumulator is cleared in the cycle its result is presented, so each result contains only the products of its own sample.
- R7: Accumulation wraps modulo 2^ACC_W in two's complement, with no saturation.
- R8: coef_we=1 on an edge writes coef_wdata to tap coef_addr, where 0 <= coef_addr < NTAPS. The new value is used by every sample accepted after that write. Writes are made only while in_ready is 1 and no result is pending.
- R9: in_ready drops right after an accepting edge and rises again NTAPS edges later. A new sample can therefore be accepted every NTAPS+1 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample offered |
| in_data | input | SMP_W (12) | Signed input sample |
| in_ready | output | 1 | Engine idle; sample will be accepted |
| coef_we | input | 1 | Coefficient write strobe |
| coef_addr | input | IDX_W (3) | Tap index to write |
| coef_wdata | input | COEF_W (8) | Signed coefficient value |
| out_valid | output | 1 | One-cycle result strobe |
| out_data | output | ACC_W (16) | Signed filter result |

## Verification
Each accepted sample produces a result that is due exactly NTAPS+1 edges later. in_ready is due to return NTAPS edges after acceptance.

The bench keeps its own history of accepted samples and its own coefficient array. On each accepting edge it computes the expected sum and queues it with the cycle number in which it is due. On every falling edge it compares in_ready, out_valid and, when a result is due, out_data against that schedule. An early, late, doubled or missing strobe is therefore caught in the exact cycle it goes wrong.

// File: rtl/fir_mac_pkg.sv
package fir_mac_pkg;
  typedef enum logic {SEQ_IDLE = 1'b0, SEQ_RUN = 1'b1} seq_state_t;

  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/fir_coef_store.sv
module fir_coef_store #(
  parameter int NTAPS  = 8,
  parameter int COEF_W = 8,
  parameter int IDX_W  = 3
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [IDX_W-1:0]         waddr,
  input  logic signed [COEF_W-1:0] wdata,
  input  logic [IDX_W-1:0]         raddr,
  output logic signed [COEF_W-1:0] rdata
);
  logic signed [COEF_W-1:0] mem [NTAPS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

  // R8
  addr_range_chk: assert property (@(posedge clk) we |-> (int'(waddr) < NTAPS))
    else $error("coefficient address out of range");
endmodule

// File: rtl/fir_delay_line.sv
module fir_delay_line #(
  parameter int NTAPS = 8,
  parameter int SMP_W = 12,
  parameter int IDX_W = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    shift,
  input  logic signed [SMP_W-1:0] din,
  input  logic [IDX_W-1:0]        sel,
  output logic signed [SMP_W-1:0] dout
);
  logic signed [SMP_W-1:0] hist [NTAPS];

  always_ff @(posedge clk) begin
    if (rst) hist[0] <= '0;
    else if (shift) hist[0] <= din;
  end

  for (genvar i = 1; i < NTAPS; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) hist[i] <= '0;
      else if (shift) hist[i] <= hist[i-1];
    end
  end

  assign dout = hist[sel];

  // R3
  shift_in_chk: assert property (@(posedge clk) disable iff (rst)
    shift |=> (hist[0] == $past(din)))
    else $error("newest sample not captured");
endmodule

// File: rtl/fir_tap_seq.sv
module fir_tap_seq
  import fir_mac_pkg::*;
#(
  parameter int NTAPS = 8,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  output logic             ready,
  output logic [IDX_W-1:0] idx,
  output logic             issue,
  output logic             issue_last
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NTAPS - 1);

  seq_state_t state;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= SEQ_IDLE;
      idx   <= '0;
    end else if (state == SEQ_IDLE) begin
      if (start) begin
        state <= SEQ_RUN;
        idx   <= '0;
      end
    end else if (idx == LAST_IDX) begin
      state <= SEQ_IDLE;
      idx   <= '0;
    end else begin
      idx <= idx + 1'b1;
    end
  end

  assign ready      = (state == SEQ_IDLE);
  assign issue      = (state == SEQ_RUN);
  assign issue_last = issue && (idx == LAST_IDX);

  // R9
  last_idle_chk: assert property (@(posedge clk) disable iff (rst)
    issue_last |=> ready)
    else $error("sequencer did not return to idle");

  // R2
  busy_after_start_chk: assert property (@(posedge clk) disable iff (rst)
    start |=> !ready)
    else $error("ready high right after start");
endmodule

// File: rtl/fir_mac_unit.sv
module fir_mac_unit #(
  parameter int NTAPS  = 8,
  parameter int SMP_W  = 12,
  parameter int COEF_W = 8,
  parameter int ACC_W  = 16,
  parameter int DROP   = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     issue,
  input  logic                     issue_last,
  input  logic signed [COEF_W-1:0] coef,
  input  logic signed [SMP_W-1:0]  sample,
  output logic                     out_valid,
  output logic signed [ACC_W-1:0]  out_data
);
  localparam int PROD_W = SMP_W + COEF_W;
  localparam int SCL_W  = PROD_W - DROP;
  localparam int CNT_W  = $clog2(NTAPS + 1);

  logic signed [PROD_W-1:0] full_prod;
  logic signed [SCL_W-1:0]  shr_prod;
  logic signed [ACC_W-1:0]  scaled;
  logic signed [ACC_W-1:0]  prod_q;
  logic                     prod_vld, prod_last;
  logic signed [ACC_W-1:0]  acc;
  logic signed [ACC_W-1:0]  acc_next;

  assign full_prod = coef * sample;
  assign shr_prod  = full_prod[PROD_W-1:DROP];

  if (ACC_W > SCL_W) begin : g_ext
    assign scaled = {{(ACC_W-SCL_W){shr_prod[SCL_W-1]}}, shr_prod};
  end else begin : g_trunc
    assign scaled = shr_prod[ACC_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prod_q    <= '0;
      prod_vld  <= 1'b0;
      prod_last <= 1'b0;
    end else begin
      prod_q    <= scaled;
      prod_vld  <= issue;
      prod_last <= issue_last;
    end
  end

  assign acc_next = acc + prod_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc       <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= prod_vld && prod_last;
      if (prod_vld) begin
        if (prod_last) begin
          out_data <= acc_next;
          acc      <= '0;
        end else begin
          acc <= acc_next;
        end
      end
    end
  end

  logic [CNT_W-1:0] seen;
  always_ff @(posedge clk) begin
    if (rst) seen <= '0;
    else if (prod_vld) seen <= prod_last ? '0 : seen + 1'b1;
  end

  // R5
  tap_count_chk: assert property (@(posedge clk) disable iff (rst)
    (prod_vld && prod_last) |-> (int'(seen) == NTAPS - 1))
    else $error("wrong number of products accumulated");

  // R5
  pulse_once_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid)
    else $error("out_valid longer than one cycle");

  // R6
  acc_clear_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (acc == '0))
    else $error("accumulator not cleared with result");
endmodule

// File: rtl/fir_mac_engine.sv
module fir_mac_engine
  import fir_mac_pkg::*;
#(
  parameter int NTAPS  = 8,
  parameter int SMP_W  = 12,
  parameter int COEF_W = 8,
  parameter int ACC_W  = 16,
  parameter int DROP   = 4,
  parameter int IDX_W  = idx_width(NTAPS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [SMP_W-1:0]  in_data,
  output logic              in_ready,
  input  logic              coef_we,
  input  logic [IDX_W-1:0]  coef_addr,
  input  logic [COEF_W-1:0] coef_wdata,
  output logic              out_valid,
  output logic [ACC_W-1:0]  out_data
);
  logic                     accept;
  logic [IDX_W-1:0]         tap_idx;
  logic                     issue, issue_last;
  logic signed [COEF_W-1:0] coef_rd;
  logic signed [SMP_W-1:0]  smp_rd;
  logic signed [ACC_W-1:0]  result;

  assign accept = in_valid && in_ready;

  fir_tap_seq #(.NTAPS(NTAPS), .IDX_W(IDX_W)) seq_i (
    .clk(clk), .rst(rst), .start(accept), .ready(in_ready),
    .idx(tap_idx), .issue(issue), .issue_last(issue_last)
  );

  fir_delay_line #(.NTAPS(NTAPS), .SMP_W(SMP_W), .IDX_W(IDX_W)) dly_i (
    .clk(clk), .rst(rst), .shift(accept), .din($signed(in_data)),
    .sel(tap_idx), .dout(smp_rd)
  );

  fir_coef_store #(.NTAPS(NTAPS), .COEF_W(COEF_W), .IDX_W(IDX_W)) coef_i (
    .clk(clk), .we(coef_we), .waddr(coef_addr), .wdata($signed(coef_wdata)),
    .raddr(tap_idx), .rdata(coef_rd)
  );

  fir_mac_unit #(.NTAPS(NTAPS), .SMP_W(SMP_W), .COEF_W(COEF_W),
                 .ACC_W(ACC_W), .DROP(DROP)) mac_i (
    .clk(clk), .rst(rst), .issue(issue), .issue_last(issue_last),
    .coef(coef_rd), .sample(smp_rd), .out_valid(out_valid), .out_data(result)
  );

  assign out_data = result;

  // R2
  no_accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (issue && !issue_last) |-> !in_ready)
    else $error("ready while taps outstanding");
endmodule

// File: tb/fir_mac_engine_tb.sv
module fir_mac_engine_tb_top;
  localparam int NTAPS = 8;
  localparam int SMP_W = 12;
  localparam int COEF_W = 8;
  localparam int ACC_W = 16;
  localparam int DROP = 4;
  localparam int IDX_W = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [SMP_W-1:0] in_data = '0;
  logic in_ready;
  logic coef_we = 1'b0;
  logic [IDX_W-1:0] coef_addr = '0;
  logic [COEF_W-1:0] coef_wdata = '0;
  logic out_valid;
  logic [ACC_W-1:0] out_data;

  always #2 clk = ~clk;

  fir_mac_engine #(.NTAPS(NTAPS), .SMP_W(SMP_W), .COEF_W(COEF_W),
                   .ACC_W(ACC_W), .DROP(DROP), .IDX_W(IDX_W)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .coef_we(coef_we), .coef_addr(coef_addr),
    .coef_wdata(coef_wdata), .out_valid(out_valid), .out_data(out_data)
  );

  int checks = 0;
  int errors = 0;
  string tag = "R3";
  bit done = 1'b0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  // reference model
  int cyc = 0;
  int busy_until = 0;
  bit ready_m = 1'b1;
  int coef_m [NTAPS];
  int hist_m [NTAPS];
  int due_q[$];
  logic [ACC_W-1:0] val_q[$];

  always @(posedge clk) begin
    if (rst) begin
      cyc = 0; busy_until = 0; ready_m = 1'b1;
      for (int i = 0; i < NTAPS; i++) hist_m[i] = 0;
      due_q.delete(); val_q.delete();
    end else begin
      cyc++;
      if (coef_we) coef_m[coef_addr] = $signed(coef_wdata);
      if (in_valid && ready_m) begin
        logic [ACC_W-1:0] y;
        for (int i = NTAPS-1; i > 0; i--) hist_m[i] = hist_m[i-1];
        hist_m[0] = $signed(in_data);
        y = '0;
        for (int k = 0; k < NTAPS; k++) begin
          int p;
          p = coef_m[k] * hist_m[k];
          y = y + ACC_W'(p >>> DROP);
        end
        due_q.push_back(cyc + NTAPS + 1);
        val_q.push_back(y);
        busy_until = cyc + NTAPS;
      end
      ready_m = (cyc >= busy_until);
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      bit exp_v;
      exp_v = (due_q.size() > 0) && (due_q[0] == cyc);
      chk(in_ready == ready_m, "R9", "in_ready", int'(in_ready), int'(ready_m));
      chk(out_valid == exp_v, "R5", "out_valid", int'(out_valid), int'(exp_v));
      if (exp_v) begin
        chk(out_data == val_q[0], tag, "out_data",
            int'($signed(out_data)), int'($signed(val_q[0])));
        void'(due_q.pop_front());
        void'(val_q.pop_front());
      end
    end
  end

  task automatic wr_coef(input int a, input int v);
    coef_we = 1'b1; coef_addr = IDX_W'(a); coef_wdata = COEF_W'(v);
    @(negedge clk);
    coef_we = 1'b0;
  endtask

  task automatic send(input int x);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1; in_data = SMP_W'(x);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic drain();
    repeat (NTAPS + 4) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state at the ports
    chk(out_valid == 1'b0, "R1", "out_valid", int'(out_valid), 0);
    chk(out_data == '0, "R1", "out_data", int'(out_data), 0);
    chk(in_ready == 1'b1, "R1", "in_ready", int'(in_ready), 1);

    // R8: load coefficients k+1
    for (int k = 0; k < NTAPS; k++) wr_coef(k, k + 1);
    // R1: first impulse sees an all-zero history; R3 impulse response
    tag = "R1";
    send(16);
    drain();
    tag = "R3";
    for (int i = 0; i < NTAPS; i++) send(0);
    send(48); send(-32); send(5);
    drain();

    // R4: negative products floor under the arithmetic shift
    tag = "R4";
    for (int k = 0; k < NTAPS; k++) wr_coef(k, (k % 2 == 0) ? -1 : 3);
    send(-3); send(7); send(-17); send(1);
    drain();

    // R2: in_valid held high while busy, data changing every cycle
    tag = "R2";
    in_valid = 1'b1;
    for (int c = 0; c < 5 * (NTAPS + 1); c++) begin
      in_data = SMP_W'(c * 37 - 600);
      @(negedge clk);
    end
    in_valid = 1'b0;
    drain();

    // R6: varied stream, each result independent of the last
    tag = "R6";
    for (int k = 0; k < NTAPS; k++) wr_coef(k, 40 - 13 * k);
    for (int s = 0; s < 20; s++) send(((s * 911) % 4096) - 2048);
    drain();

    // R7: wrap modulo 2^16 with no clamp
    tag = "R7";
    for (int k = 0; k < NTAPS; k++) wr_coef(k, 127);
    for (int s = 0; s < NTAPS + 2; s++) send(2047);
    for (int s = 0; s < NTAPS + 2; s++) send(-2048);
    drain();

    // R8: a single rewrite changes later samples only
    tag = "R8";
    wr_coef(3, -128);
    send(100); send(-1); send(2000);
    drain();
    chk(due_q.size() == 0, "R5", "pending results", due_q.size(), 0);

    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    finish_run();
  end
endmodule